// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives one outgoing low-speed USB packet onto the D+ and D- lines. A start strobe makes it claim the bus. It holds the idle J level for one bit time, then sends the sync byte, then the payload bytes. Each byte goes out least significant bit first. The bits are NRZI encoded, and a stuffed transition is added after six ones in a row. The packet closes with an end-of-packet pattern, and then both drivers are released. Every bit lasts a fixed number of clock cycles, 8 by default.

Payload bytes arrive on a ready/valid stream, and a byte count given at the start sets how many there are. A handshake mode sends only the sync byte and one PID byte, taken from a port captured at the start; in that mode the stream is never read. A pending device address is copied into the active address register when a data packet ends. It is never copied when a handshake packet ends. If the stream has no byte ready when one is needed, the block latches an underrun flag and still closes the packet cleanly.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset and after every packet, oe_o, dp_o, dm_o and busy_o are all 0.
- R2: A start_i accepted while idle drives oe_o=1 with J (dp_o=0, dm_o=1) for exactly BIT_CYCLES cycles, counted from the accepting edge. The first sync bit follows straight after. A start_i raised while busy is ignored.
- R3: The sync byte is 0x80 sent LSB first, so the eight bit times after the leading J read K J K J K J K K (K is dp_o=1, dm_o=0).
- R4: Each bit lasts BIT_CYCLES cycles. A 0 bit toggles the line between J and K, and a 1 bit keeps the line as it is. Payload bytes go out LSB first, in stream order.
- R5: After six consecutive 1 bits, counted across byte borders and including the trailing 1 of sync, one extra toggled bit time is inserted. This also happens after the last data bit. A 0 bit or an inserted bit restarts the count.
- R6: After the last bit (or stuffed bit), the block drives SE0 (dp_o=dm_o=0, oe_o=1) for two bit times and then J for one bit time. Then oe_o drops, busy_o falls, and done_o pulses high for one cycle.
- R7: With hshk_i=1 at start, the packet is sync followed by hshk_pid_i, and data_ready_o stays 0 for the whole packet.
- R8: If data_valid_i is 0 when the next payload byte is needed, underrun_o is set and held until the next start. The packet then proceeds to R6 after the bytes already accepted.
- R9: When a data packet ends with addr_pend_i=1, dev_addr_o takes new_addr_i in the cycle of done_o. When a handshake packet ends, dev_addr_o keeps its value.
- R10: data_ready_o pulses once per payload byte, on the last cycle of the previous byte's final bit. byte_count_i payload bytes are taken, and a count of 0 sends sync only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, BIT_CYCLES cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| hshk_i | input | 1 | Send a handshake packet (sync + PID) |
| hshk_pid_i | input | 8 | Handshake PID byte |
| byte_count_i | input | CNT_W | Payload bytes after sync (data mode) |
| data_i | input | 8 | Payload byte stream |
| data_valid_i | input | 1 | Stream byte valid |
| data_ready_o | output | 1 | Stream byte taken this cycle |
| addr_pend_i | input | 1 | A new device address waits for commit |
| new_addr_i | input | ADDR_W | Address to commit |
| dev_addr_o | output | ADDR_W | Active device address |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse at packet end |
| underrun_o | output | 1 | Stream underrun in last packet |

## Verification
A zero byte and a mixed byte check the NRZI toggle rule on their own, with no stuffing involved. Runs of 0xFF, and a byte whose top six bits are ones, bring in stuffed bit times inside bytes, across byte borders and just before the end-of-packet pattern. Handshake packets and data packets are each sent with a pending address, which shows whether the commit depends on packet type. A short stream and a zero byte count separate underrun from a normal early end. The bench compares the lines at the first and last cycle of every bit time, so any one-cycle shift in timing shows up.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int BIDX_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_SE0A,
    ST_SE0B,
    ST_TAILJ
  } tx_state_e;

  typedef struct packed {
    logic oe;
    logic dp;
    logic dm;
  } pins_t;

  // line pins for a state; ln_k=1 means K, 0 means J
  function automatic pins_t pins_for(tx_state_e st, logic ln_k);
    pins_t p;
    case (st)
      ST_LEAD, ST_BITS: p = '{oe: 1'b1, dp: ln_k, dm: ~ln_k};
      ST_SE0A, ST_SE0B: p = '{oe: 1'b1, dp: 1'b0, dm: 1'b0};
      ST_TAILJ:         p = '{oe: 1'b1, dp: 1'b0, dm: 1'b1};
      default:          p = '{oe: 1'b0, dp: 1'b0, dm: 1'b0};
    endcase
    return p;
  endfunction

  function automatic logic in_bit_phase(tx_state_e st);
    return (st == ST_LEAD) || (st == ST_BITS);
  endfunction

endpackage

// File: rtl/usb_ls_tx_bitclk.sv
module usb_ls_tx_bitclk #(
  parameter int BIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(BIT_CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i || !run_i)   cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && !clr_i && (cnt_q == LAST);

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_tick_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi #(
  parameter int ONES_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic step_i,
  input  logic bit_i,
  output logic ln_k_o,
  output logic stuff_due_o
);
  localparam int W = $clog2(ONES_MAX + 1);
  localparam logic [W-1:0] RELOAD = W'(ONES_MAX);

  logic [W-1:0] ones_q;
  logic         ln_k_q;

  // remaining ones before a stuffed bit is owed
  function automatic logic [W-1:0] ones_next(logic [W-1:0] cur, logic b);
    return b ? (cur - 1'b1) : RELOAD;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= RELOAD;
      ln_k_q <= 1'b0;
    end else if (init_i) begin
      ones_q <= RELOAD;
      ln_k_q <= 1'b0;
    end else if (step_i) begin
      if (stuff_due_o) begin
        ones_q <= RELOAD;
        ln_k_q <= ~ln_k_q;
      end else begin
        ones_q <= ones_next(ones_q, bit_i);
        if (!bit_i) ln_k_q <= ~ln_k_q;
      end
    end
  end

  assign stuff_due_o = (ones_q == '0);
  assign ln_k_o      = ln_k_q;

  assert_ones_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RELOAD);

  assert_stuff_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i && stuff_due_o) |=> (ln_k_o != $past(ln_k_o)));

  assert_one_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i && !stuff_due_o && bit_i) |=> $stable(ln_k_o));

endmodule

// File: rtl/usb_ls_tx_addr.sv
module usb_ls_tx_addr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              pend_i,
  input  logic [ADDR_W-1:0] new_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  addr_q <= '0;
    else if (commit_i && pend_i) addr_q <= new_i;
  end

  assign addr_o = addr_q;

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(addr_o));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 8,
  parameter int ONES_MAX   = 6,
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hshk_i,
  input  logic [7:0]        hshk_pid_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  input  logic              addr_pend_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underrun_o
);
  localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(BYTE_W - 1);

  tx_state_e         state_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [CNT_W-1:0]  left_q;
  logic              avail_q;
  logic              hs_q;
  logic [7:0]        pid_q;
  logic              under_q;
  logic              done_q;

  // named internal events
  logic tick_w, start_acc_w, stuff_due_w, ln_k_w;
  logic bit_slot_w, emit_w, step_w, fetch_w, take_w, commit_w;
  pins_t pins_w;

  assign start_acc_w = (state_q == ST_IDLE) && start_i;
  assign bit_slot_w  = tick_w && in_bit_phase(state_q);
  assign emit_w      = bit_slot_w && !stuff_due_w && avail_q;
  assign step_w      = bit_slot_w && (stuff_due_w || avail_q);
  assign fetch_w     = emit_w && (bidx_q == LAST_BIT) && (left_q != '0);
  assign take_w      = fetch_w && (hs_q || data_valid_i);
  assign commit_w    = tick_w && (state_q == ST_TAILJ) && !hs_q;

  usb_ls_tx_bitclk #(.BIT_CYCLES(BIT_CYCLES)) bitclk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_acc_w),
    .run_i (state_q != ST_IDLE),
    .tick_o(tick_w)
  );

  usb_ls_tx_nrzi #(.ONES_MAX(ONES_MAX)) nrzi_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (start_acc_w),
    .step_i     (step_w),
    .bit_i      (shreg_q[bidx_q]),
    .ln_k_o     (ln_k_w),
    .stuff_due_o(stuff_due_w)
  );

  usb_ls_tx_addr #(.ADDR_W(ADDR_W)) addr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit_i(commit_w),
    .pend_i  (addr_pend_i),
    .new_i   (new_addr_i),
    .addr_o  (dev_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bidx_q  <= '0;
      left_q  <= '0;
      avail_q <= 1'b0;
      hs_q    <= 1'b0;
      pid_q   <= '0;
      under_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LEAD;
            shreg_q <= SYNC_BYTE;
            bidx_q  <= '0;
            avail_q <= 1'b1;
            hs_q    <= hshk_i;
            pid_q   <= hshk_pid_i;
            left_q  <= hshk_i ? CNT_W'(1) : byte_count_i;
            under_q <= 1'b0;
          end
        end
        ST_LEAD, ST_BITS: begin
          if (tick_w) begin
            state_q <= (stuff_due_w || avail_q) ? ST_BITS : ST_SE0A;
            if (emit_w) begin
              if (bidx_q != LAST_BIT) begin
                bidx_q <= bidx_q + 1'b1;
              end else if (left_q == '0) begin
                avail_q <= 1'b0;
              end else if (take_w) begin
                shreg_q <= hs_q ? pid_q : data_i;
                left_q  <= left_q - 1'b1;
                bidx_q  <= '0;
              end else begin
                under_q <= 1'b1;
                avail_q <= 1'b0;
              end
            end
          end
        end
        ST_SE0A:  if (tick_w) state_q <= ST_SE0B;
        ST_SE0B:  if (tick_w) state_q <= ST_TAILJ;
        ST_TAILJ: if (tick_w) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pins_w       = pins_for(state_q, ln_k_w);
  assign oe_o         = pins_w.oe;
  assign dp_o         = pins_w.dp;
  assign dm_o         = pins_w.dm;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign underrun_o   = under_q;
  assign data_ready_o = fetch_w && !hs_q;

  assert_no_se1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_o && dm_o));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !oe_o));

  assert_lead_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (oe_o && !dp_o && dm_o));

  assert_line_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(tick_w)) |-> $stable({oe_o, dp_o, dm_o}));

  assert_no_ready_hshk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && hs_q) |-> !data_ready_o);

  assert_under_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !start_acc_w) |=> underrun_o);

  assert_addr_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_addr_o != $past(dev_addr_o)) |-> done_o);

endmodule

// File: tb/usb_ls_tx_tb_top.sv
module usb_ls_tx_tb_top;
  localparam int BC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, hshk_i = 1'b0, addr_pend_i = 1'b0;
  logic [7:0] hshk_pid_i = '0, byte_count_i = '0;
  logic [6:0] new_addr_i = '0;
  logic [7:0] data_i;
  logic data_valid_i, data_ready_o;
  logic [6:0] dev_addr_o;
  logic dp_o, dm_o, oe_o, busy_o, done_o, underrun_o;

  logic [7:0] pay [0:15];
  int idx = 0, avail_n = 0;
  logic clr_idx = 1'b0;
  int n_chk = 0, n_err = 0;
  bit ended = 0;
  int sym [0:511];
  int nsym;

  always #2.5 clk = ~clk;

  assign data_i       = (idx < 16) ? pay[idx] : 8'h00;
  assign data_valid_i = (idx < avail_n);

  always @(posedge clk) begin
    if (clr_idx) idx <= 0;
    else if (data_ready_o && data_valid_i) idx <= idx + 1;
  end

  usb_ls_tx dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hshk_i(hshk_i),
    .hshk_pid_i(hshk_pid_i), .byte_count_i(byte_count_i), .data_i(data_i),
    .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
    .addr_pend_i(addr_pend_i), .new_addr_i(new_addr_i), .dev_addr_o(dev_addr_o),
    .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o),
    .underrun_o(underrun_o)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // symbols: 0 idle, 1 J, 2 K, 3 SE0 -> {oe,dp,dm}
  function automatic int pins_of(int s);
    case (s)
      1: return 3'b101;
      2: return 3'b110;
      3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string slot_tag(int k, int n);
    if (k == 0) return "R2 lead J";
    if (k <= 8) return "R3 sync";
    if (k >= n - 3) return "R6 eop";
    return "R4/R5 data";
  endfunction

  // independent line model: NRZI plus stuffing after six ones
  task automatic build(input bit hs, input [7:0] pid, input int nbytes);
    int line, ones;
    logic [7:0] b;
    nsym = 0; line = 1; ones = 6;
    sym[nsym++] = 1;
    for (int i = 0; i <= nbytes; i++) begin
      b = (i == 0) ? 8'h80 : (hs ? pid : pay[i-1]);
      for (int j = 0; j < 8; j++) begin
        if (b[j]) ones--;
        else begin ones = 6; line = 3 - line; end
        sym[nsym++] = line;
        if (ones == 0) begin
          line = 3 - line; ones = 6;
          sym[nsym++] = line;
        end
      end
    end
    sym[nsym++] = 3; sym[nsym++] = 3; sym[nsym++] = 1;
  endtask

  task automatic run_pkt(input string nm, input bit hs, input [7:0] pid,
                         input int n, input int avail, input bit pend,
                         input [6:0] naddr, input bit poke);
    int took;
    logic [6:0] exp_addr;
    took = hs ? 0 : ((avail < n) ? avail : n);
    build(hs, pid, hs ? 1 : took);
    exp_addr = (!hs && pend) ? naddr : dev_addr_o;
    @(negedge clk);
    clr_idx = 1; avail_n = avail; hshk_i = hs; hshk_pid_i = pid;
    byte_count_i = 8'(n); addr_pend_i = pend; new_addr_i = naddr;
    @(negedge clk);
    clr_idx = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < nsym; k++) begin
      int a0, a1;
      a0 = {oe_o, dp_o, dm_o};
      if (poke && k == 5) begin
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (6) @(negedge clk);
      end else begin
        repeat (7) @(negedge clk);
      end
      a1 = {oe_o, dp_o, dm_o};
      check({nm, " ", slot_tag(k, nsym)}, (a0 << 4) | a1,
            (pins_of(sym[k]) << 4) | pins_of(sym[k]));
      @(negedge clk);
    end
    check({nm, " R6 done pulse"}, done_o, 1);
    check({nm, " R1 idle after"}, {oe_o, dp_o, dm_o, busy_o}, 0);
    check({nm, " R8 underrun"}, underrun_o, (!hs && avail < n) ? 1 : 0);
    check({nm, " R10 bytes taken"}, idx, took);
    check({nm, " R9 address"}, dev_addr_o, exp_addr);
    @(negedge clk);
    check({nm, " R6 done one cycle"}, done_o, 0);
  endtask

  task automatic t_reset();
    check("R1 reset pins/busy", {oe_o, dp_o, dm_o, busy_o, done_o}, 0);
    check("R9 reset address", dev_addr_o, 0);
    check("R8 reset underrun", underrun_o, 0);
  endtask

  task automatic t_plain();
    pay[0] = 8'h00; pay[1] = 8'h5A; pay[2] = 8'hC3;
    run_pkt("plain R4", 0, 8'h00, 3, 3, 0, 7'h00, 1);
  endtask

  task automatic t_stuff_runs();
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h3F; pay[3] = 8'h01;
    run_pkt("ones R5", 0, 8'h00, 4, 4, 0, 7'h00, 0);
  endtask

  task automatic t_stuff_tail();
    pay[0] = 8'h12; pay[1] = 8'hFC;
    run_pkt("tail R5", 0, 8'h00, 2, 2, 0, 7'h00, 0);
  endtask

  task automatic t_hshk();
    pay[0] = 8'hAA;
    run_pkt("ack R7", 1, 8'hD2, 5, 5, 1, 7'h15, 0);
    run_pkt("nak R7", 1, 8'h5A, 0, 0, 1, 7'h2B, 0);
  endtask

  task automatic t_addr();
    pay[0] = 8'h4B; pay[1] = 8'h00;
    run_pkt("data R9", 0, 8'h00, 2, 2, 1, 7'h3C, 0);
    run_pkt("ack R9 keep", 1, 8'hD2, 0, 0, 1, 7'h11, 0);
  endtask

  task automatic t_underrun();
    pay[0] = 8'h7F; pay[1] = 8'h80;
    run_pkt("short R8", 0, 8'h00, 3, 1, 1, 7'h05, 0);
    run_pkt("full R8 clear", 0, 8'h00, 2, 2, 0, 7'h00, 0);
  endtask

  task automatic t_empty();
    run_pkt("empty R10", 0, 8'h00, 0, 4, 0, 7'h00, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) pay[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_stuff_runs();
    t_stuff_tail();
    t_hshk();
    t_addr();
    t_underrun();
    t_empty();
    finish_run();
  end

endmodule